// File: doc/BRIEF.md
# Bus-Arbitrated Packet Transmit Sequencer

This block sends one packet from a local byte buffer over a shared serial bus. Bus ownership is arbitrated on a separate open-drain attention line. When a send is requested, the sequencer looks at the synchronized attention level with its own drive released. If another node already holds the line low, the request ends at once with a busy code. If the line is free, the sequencer claims it by pulling it low and waits a guard interval of two bit times.

After the guard interval it reads the length field from the buffer and streams the packet bytes, starting at offset 0, to a byte transmitter. It hands over one byte at a time and waits for the transmitter to report that the byte has finished. If the transmitter reports a collision on any byte, the rest of the packet is dropped. When the packet ends, or when it is aborted, the attention line is released and a one-cycle done pulse carries a two-bit status code.

The buffer read port is combinational: the buffer returns data for `rd_addr_o` in the same cycle. Bit-level serialization, checksum generation and queue management are handled outside this block.

Top module: `pkt_tx_seq`

## Requirements
- R1: Out of reset, `attn_drive_o`, `tx_start_o` and `done_o` are 0 and `status_o` is 2'b00.
- R2: The raw `attn_i` level passes through two flip-flops before the sequencer uses it. If `start_i` is sampled while the synchronized level is low, `done_o` pulses in the next cycle with `status_o` = 2'b01 (busy). In that case `attn_drive_o` stays 0 and no byte is started.
- R3: If `start_i` is sampled while the synchronized level is high, `attn_drive_o` (1 = pull the line low) goes to 1 in the next cycle. It stays 1 without a break until the cycle in which `done_o` pulses. The line is never driven high.
- R4: The first `tx_start_o` pulse comes exactly 2*B cycles after `attn_drive_o` rises. B is the `bit_time_i` value sampled together with `start_i`, and a value of 0 counts as 1. Later changes to `bit_time_i` do not affect a packet that is already in progress.
- R5: The packet contains L+3 bytes, where L is the buffer byte at offset 1.
- R6: Bytes are presented on `tx_byte_o` in buffer order from offset 0 upward. Each byte gets a one-cycle `tx_start_o`. The next byte starts only after `tx_done_i` has been seen for the current byte.
- R7: If `tx_done_i` arrives together with `tx_coll_i`, no further byte is started. In the next cycle `done_o` pulses with `status_o` = 2'b10 and `attn_drive_o` is 0.
- R8: If `tx_done_i` arrives without `tx_coll_i` for the last byte, then in the next cycle `done_o` pulses with `status_o` = 2'b00 and `attn_drive_o` is 0.
- R9: `done_o` is high for exactly one cycle per request. `status_o` is never 2'b11 while `done_o` is high.
- R10: A `start_i` that arrives while a packet is in progress is ignored. No second packet and no extra done pulse follow from it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request to send the buffered packet |
| bit_time_i | input | CNT_W | Bit time in clock cycles |
| attn_i | input | 1 | Raw level of the attention line |
| attn_drive_o | output | 1 | 1 = pull the attention line low |
| rd_addr_o | output | ADDR_W | Buffer read address |
| rd_data_i | input | 8 | Buffer data at `rd_addr_o` (same cycle) |
| tx_start_o | output | 1 | One-cycle strobe that hands a byte to the transmitter |
| tx_byte_o | output | 8 | Byte handed to the transmitter |
| tx_done_i | input | 1 | The transmitter has finished the current byte |
| tx_coll_i | input | 1 | Collision flag, valid together with `tx_done_i` |
| done_o | output | 1 | One-cycle end-of-request pulse |
| status_o | output | 2 | 00 ok, 01 busy, 10 collision; valid with `done_o` |

## Verification
Each result has a fixed cycle, counted from the edge at which the request or handshake is sampled:
- The busy done pulse and the rise of the attention drive each come one cycle after the start.
- The first byte strobe comes 2*B cycles after the drive rises.
- The final done pulse and the drive release come one cycle after the last transmitter handshake.

The bench drives inputs and samples outputs on the falling edge, counts falling edges from each event, and compares against exactly those offsets. It keeps the synchronizer delay in mind by letting the modeled bus settle for several cycles before every request.

// File: rtl/pkt_tx_pkg.sv
package pkt_tx_pkg;

  typedef enum logic [1:0] {
    TX_OK   = 2'b00,
    TX_BUSY = 2'b01,
    TX_COLL = 2'b10
  } tx_status_e;

  typedef enum logic [1:0] {
    S_IDLE,
    S_GUARD,
    S_SEND,
    S_WAIT
  } seq_state_e;

  // offset of the length field and the bytes it does not count
  localparam int unsigned LEN_OFFSET = 1;
  localparam int unsigned HDR_EXTRA  = 3;
  localparam int unsigned GUARD_BITS = 2;

endpackage

// File: rtl/attn_sync.sv
module attn_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] q;

  // reset to released (high) bus level
  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) q[i] <= 1'b1;
          else         q[i] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) q[i] <= 1'b1;
          else         q[i] <= q[i-1];
        end
      end
    end
  endgenerate

  assign q_o = q[STAGES-1];
endmodule

// File: rtl/guard_timer.sv
module guard_timer #(
  parameter int unsigned W = 17
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= load_val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - W'(1);
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/byte_ctr.sv
module byte_ctr #(
  parameter int unsigned AW    = 9,
  parameter int unsigned EXTRA = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          len_ld_i,
  input  logic [7:0]    len_i,
  input  logic          inc_i,
  output logic [AW-1:0] idx_o,
  output logic          last_o
);
  logic [AW-1:0] idx_q;
  logic [AW-1:0] total_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q   <= '0;
      total_q <= AW'(EXTRA);
    end else if (len_ld_i) begin
      idx_q   <= '0;
      total_q <= AW'(len_i) + AW'(EXTRA);
    end else if (inc_i) begin
      idx_q   <= idx_q + AW'(1);
    end
  end

  assign idx_o  = idx_q;
  assign last_o = (idx_q == total_q - AW'(1));
endmodule

// File: rtl/pkt_tx_seq.sv
module pkt_tx_seq
  import pkt_tx_pkg::*;
#(
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned ADDR_W      = 9,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [CNT_W-1:0]  bit_time_i,
  input  logic              attn_i,
  output logic              attn_drive_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic [7:0]        rd_data_i,
  output logic              tx_start_o,
  output logic [7:0]        tx_byte_o,
  input  logic              tx_done_i,
  input  logic              tx_coll_i,
  output logic              done_o,
  output logic [1:0]        status_o
);
  localparam int unsigned GW = CNT_W + 1;

  seq_state_e    state_q;
  tx_status_e    status_q;
  logic          drive_q;
  logic          done_q;
  logic          attn_s;
  logic          tmr_load;
  logic          tmr_zero;
  logic [CNT_W-1:0] bit_eff;
  logic [GW-1:0] guard_val;
  logic          len_ld;
  logic          ctr_inc;
  logic          last_byte;
  logic [ADDR_W-1:0] idx;

  attn_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (attn_i),
    .q_o   (attn_s)
  );

  assign bit_eff   = (bit_time_i == '0) ? CNT_W'(1) : bit_time_i;
  assign guard_val = GW'(GUARD_BITS) * GW'(bit_eff) - GW'(1);
  assign tmr_load  = (state_q == S_IDLE) && start_i && attn_s;

  guard_timer #(.W(GW)) u_guard (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (tmr_load),
    .load_val_i(guard_val),
    .zero_o    (tmr_zero)
  );

  assign len_ld  = (state_q == S_GUARD) && tmr_zero;
  assign ctr_inc = (state_q == S_WAIT) && tx_done_i && !tx_coll_i && !last_byte;

  byte_ctr #(.AW(ADDR_W), .EXTRA(HDR_EXTRA)) u_ctr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .len_ld_i(len_ld),
    .len_i   (rd_data_i),
    .inc_i   (ctr_inc),
    .idx_o   (idx),
    .last_o  (last_byte)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= S_IDLE;
      status_q <= TX_OK;
      drive_q  <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        S_IDLE: begin
          if (start_i) begin
            if (!attn_s) begin
              done_q   <= 1'b1;
              status_q <= TX_BUSY;
            end else begin
              drive_q <= 1'b1;
              state_q <= S_GUARD;
            end
          end
        end
        S_GUARD: if (tmr_zero) state_q <= S_SEND;
        S_SEND:  state_q <= S_WAIT;
        S_WAIT: begin
          if (tx_done_i) begin
            if (tx_coll_i) begin
              done_q   <= 1'b1;
              status_q <= TX_COLL;
              drive_q  <= 1'b0;
              state_q  <= S_IDLE;
            end else if (last_byte) begin
              done_q   <= 1'b1;
              status_q <= TX_OK;
              drive_q  <= 1'b0;
              state_q  <= S_IDLE;
            end else begin
              state_q <= S_SEND;
            end
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign rd_addr_o    = (state_q == S_GUARD) ? ADDR_W'(LEN_OFFSET) : idx;
  assign tx_start_o   = (state_q == S_SEND);
  assign tx_byte_o    = rd_data_i;
  assign attn_drive_o = drive_q;
  assign done_o       = done_q;
  assign status_o     = status_q;
endmodule

// File: rtl/pkt_tx_seq_checker.sv
module pkt_tx_seq_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       start_i,
  input logic       attn_drive_o,
  input logic       tx_start_o,
  input logic       tx_done_i,
  input logic       tx_coll_i,
  input logic       done_o,
  input logic [1:0] status_o
);
  a_r2_busy_no_drive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && status_o == 2'b01) |-> ($past(start_i) && !$past(attn_drive_o) && !attn_drive_o));

  a_r4_start_needs_drive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_start_o |-> attn_drive_o);

  a_r6_single_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_start_o |=> !tx_start_o);

  a_r7_coll_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && status_o == 2'b10) |-> ($past(tx_done_i && tx_coll_i) && !attn_drive_o));

  a_r8_ok_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && status_o == 2'b00) |-> ($past(tx_done_i && !tx_coll_i) && !attn_drive_o));

  a_r9_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r9_status_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (status_o != 2'b11));

  a_r3_release_on_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(attn_drive_o) |-> done_o);
endmodule

bind pkt_tx_seq pkt_tx_seq_checker u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .attn_drive_o(attn_drive_o),
  .tx_start_o  (tx_start_o),
  .tx_done_i   (tx_done_i),
  .tx_coll_i   (tx_coll_i),
  .done_o      (done_o),
  .status_o    (status_o)
);

// File: tb/pkt_tx_seq_test.sv
module pkt_tx_seq_test;
  localparam int CNT_W  = 16;
  localparam int ADDR_W = 9;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              start_i = 1'b0;
  logic [CNT_W-1:0]  bit_time_i = '0;
  logic              attn_i;
  logic              attn_drive_o;
  logic [ADDR_W-1:0] rd_addr_o;
  logic [7:0]        rd_data_i;
  logic              tx_start_o;
  logic [7:0]        tx_byte_o;
  logic              tx_done_i = 1'b0;
  logic              tx_coll_i = 1'b0;
  logic              done_o;
  logic [1:0]        status_o;

  logic [7:0] mem [512];
  logic ext_hold = 1'b0;
  int n_chk = 0;
  int n_bad = 0;
  bit all_done = 1'b0;

  always #5 clk_i = ~clk_i;

  // open-drain bus: low if anyone pulls
  assign attn_i    = ~(attn_drive_o | ext_hold);
  assign rd_data_i = mem[rd_addr_o];

  pkt_tx_seq uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .bit_time_i(bit_time_i),
    .attn_i(attn_i), .attn_drive_o(attn_drive_o), .rd_addr_o(rd_addr_o),
    .rd_data_i(rd_data_i), .tx_start_o(tx_start_o), .tx_byte_o(tx_byte_o),
    .tx_done_i(tx_done_i), .tx_coll_i(tx_coll_i), .done_o(done_o), .status_o(status_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_guard(input int bt);
    return 2 * ((bt == 0) ? 1 : bt);
  endfunction

  function automatic int exp_sent(input int total, input int coll);
    return (coll >= 0 && coll < total) ? coll + 1 : total;
  endfunction

  task automatic send_pkt(input int len, input int bt, input int coll, input int dly, input bit inject);
    int total, sent, first_t, pend, t;
    bit drive_ok, order_ok, fin, stray;
    total = len + 3;
    mem[1] = 8'(len);
    for (int i = 0; i < 512; i++) if (i != 1) mem[i] = 8'($urandom_range(0, 255));
    repeat (4) @(negedge clk_i);
    bit_time_i = CNT_W'(bt);
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    bit_time_i = CNT_W'(bt + 3);  // must not affect this packet
    check(attn_drive_o == 1'b1, "R3 claim", attn_drive_o, 1);
    t = 0; sent = 0; first_t = -1; pend = 0;
    drive_ok = 1; order_ok = 1; fin = 0;
    while (!fin && t < 20000) begin
      tx_done_i = 1'b0;
      tx_coll_i = 1'b0;
      if (inject && t == 4) start_i = 1'b0;
      if (done_o) begin
        fin = 1;
      end else begin
        if (!attn_drive_o) drive_ok = 0;
        if (tx_start_o) begin
          if (sent == 0) first_t = t;
          if (tx_byte_o !== mem[sent]) order_ok = 0;
          if (pend != 0) order_ok = 0;
          sent++;
          pend = dly;
        end else if (pend > 0) begin
          pend--;
          if (pend == 0) begin
            tx_done_i = 1'b1;
            tx_coll_i = (sent - 1 == coll);
          end
        end
        if (inject && t == 3) start_i = 1'b1;
        @(negedge clk_i);
        t++;
      end
    end
    start_i = 1'b0;
    check(fin, "R9 done seen", fin, 1);
    check(drive_ok, "R3 drive held", drive_ok, 1);
    check(first_t == exp_guard(bt), "R4 guard", first_t, exp_guard(bt));
    check(order_ok, "R6 byte order", order_ok, 1);
    check(sent == exp_sent(total, coll), "R5 byte count", sent, exp_sent(total, coll));
    if (coll >= 0 && coll < total)
      check(status_o == 2'b10, "R7 coll status", status_o, 2);
    else
      check(status_o == 2'b00, "R8 ok status", status_o, 0);
    check(attn_drive_o == 1'b0, "R7 R8 release", attn_drive_o, 0);
    @(negedge clk_i);
    check(done_o == 1'b0, "R9 single pulse", done_o, 0);
    stray = 0;
    repeat (8) begin
      if (tx_start_o || done_o || attn_drive_o) stray = 1;
      @(negedge clk_i);
    end
    check(!stray, "R10 no extra activity", stray, 0);
  endtask

  task automatic busy_case();
    bit stray;
    ext_hold = 1'b1;
    repeat (4) @(negedge clk_i);
    bit_time_i = CNT_W'(2);
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    check(done_o == 1'b1, "R2 busy done", done_o, 1);
    check(status_o == 2'b01, "R2 busy status", status_o, 1);
    check(attn_drive_o == 1'b0, "R2 busy no drive", attn_drive_o, 0);
    stray = 0;
    repeat (10) begin
      @(negedge clk_i);
      if (tx_start_o || attn_drive_o || done_o) stray = 1;
    end
    check(!stray, "R2 busy nothing sent", stray, 0);
    ext_hold = 1'b0;
    repeat (4) @(negedge clk_i);
  endtask

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 512; i++) mem[i] = '0;
    repeat (3) @(negedge clk_i);
    check(!attn_drive_o && !tx_start_o && !done_o && status_o == 2'b00, "R1 reset",
          {attn_drive_o, tx_start_o, done_o, status_o}, 0);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    check(!attn_drive_o && !tx_start_o && !done_o && status_o == 2'b00, "R1 after reset",
          {attn_drive_o, tx_start_o, done_o, status_o}, 0);

    busy_case();
    send_pkt(0, 0, -1, 1, 0);    // shortest packet, zero bit time
    send_pkt(2, 3, 0, 2, 0);     // collision on first byte
    send_pkt(4, 1, 6, 1, 0);     // collision on last byte
    send_pkt(5, 2, -1, 3, 1);    // start during packet
    send_pkt(255, 1, -1, 1, 0);  // longest packet
    busy_case();
    for (int k = 0; k < 30; k++) begin
      int len, coll;
      len  = $urandom_range(0, 12);
      coll = ($urandom_range(0, 2) == 0) ? $urandom_range(0, len + 2) : -1;
      send_pkt(len, $urandom_range(0, 6), coll, $urandom_range(1, 4), $urandom_range(0, 1) == 1);
    end
    if (!all_done) begin
      all_done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk_i);
    if (!all_done) begin
      all_done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule